// File: doc/BRIEF.md
# UART Control and Status Register Bank with Interrupt Combiner

This block is the software-visible face of a serial port. A host reaches it over a simple synchronous bus (word offset, 16-bit write data, write and read strobes, registered 32-bit read data). Behind it sit the divisors, line and control settings, the receive trigger-level selection, the interrupt mask and the raw interrupt state. Serial timing and the receive buffer storage live elsewhere. The buffer reports its fill level, arrival and overrun events to this block. The block tells the buffer when a character is popped, when a character is sent out, and when a character is looped back into the receive path.

Interrupt sources (receive level crossing, transmit done, receive timeout) are kept in a raw status vector and gated by the mask. The result drives a single interrupt line. Reads of the data word pop a character and fold the receive error state into the byte above it. The top eight word offsets of the address space return fixed identification bytes.

Top module: `uart_csr_top`

## Requirements
- R1: After reset every register reads zero, except the level-select register, which reads 0x0012. The interrupt output is low after reset. Register word offsets are: data 0x00, receive status 0x01, flags 0x06, integer divisor 0x09, fractional divisor 0x0A, line control 0x0B, control 0x0C, level select 0x0D, mask 0x0E, raw status 0x0F, masked status 0x10, clear 0x11.
- R2: Writes are masked per register and the read-back equals written AND mask. The masks are fractional divisor 0x003F, line control 0x00FF, control 0xFFC7, level select 0x003F and interrupt mask 0x07FF. The integer divisor keeps all 16 bits.
- R3: Masked status reads raw status AND mask. The interrupt output is high exactly when that value is nonzero.
- R4: Writing the clear register drops every raw status bit that is 1 in the written value. Reading the clear register gives zero. A hardware set in the same cycle wins over the clear.
- R5: Any write to the receive status register clears it. An overrun pulse sets its bit 3, and an overrun wins over a simultaneous clearing write.
- R6: A data read returns the input character in bits 7:0 and the receive status in bits 15:8. It pulses the pop output in the cycle of the read and leaves the overrun bit in place.
- R7: A data write sets raw bit 5 (transmit) and presents bits 7:0 on the byte output. It pulses the send output when control bit 7 is 0 and the loopback output when control bit 7 is 1. Never both are pulsed at once.
- R8: Flags reads return bit 7 = 1 and bit 4 = (fill level is 0). Bit 6 = (fill level >= effective depth), where the effective depth is DEPTH with line-control bit 4 set and 1 without it.
- R9: Word offsets 0x3F8..0x3FB return bytes 0x11, 0x10, 0x24, 0x00 and 0x3FC..0x3FF return 0x0D, 0xF0, 0x05, 0xB1.
- R10: Unassigned offsets read zero. Writes to flags, raw status, masked status, identification and unassigned offsets change nothing.
- R11: Raw bit 4 (receive) is set when the fill level goes from below to at-or-above the trigger level between consecutive cycles. The trigger is 1 with line-control bit 4 clear. Otherwise, with level-select bits 5:3 as the selector, it is DEPTH/8, DEPTH/4, DEPTH/2, 3*DEPTH/4 or 7*DEPTH/8 for selector values 0 to 4, and DEPTH for any larger value.
- R12: Raw bit 6 (timeout) is set on an arrival pulse while the fill level is nonzero. A data read clears bit 4 if the level after the pop is below the trigger, and clears bit 6 if the level after the pop is zero.
- R13: Read data is registered: it appears one cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_char | input | 8 | Character at the head of the receive buffer |
| rx_level | input | LVL_W | Receive buffer fill level |
| rx_arrive | input | 1 | Pulse: data arrived in the receive buffer |
| rx_overrun | input | 1 | Pulse: receive buffer overflowed |
| rx_pop | output | 1 | Pulse: remove the head character |
| tx_push | output | 1 | Pulse: send tx_byte on the line |
| lb_push | output | 1 | Pulse: loop tx_byte into the receive buffer |
| tx_byte | output | 8 | Character written by the host |
| fifo_en | output | 1 | Line-control buffer enable bit |
| irq | output | 1 | Combined interrupt |

## Verification
Register writes, raw status changes and the interrupt line all take effect at the clock edge that samples the strobe. Read data also lands on that edge. So each result is due one edge after its stimulus, and the bench samples every result two time units after that edge. The push and pop outputs are combinational on the strobe and are sampled in the same cycle, before the edge. The expected raw status uses the fill level of the previous cycle for crossing detection, which matches one register of delay in the design.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

    localparam int REG_W = 16;
    localparam int IRQ_W = 11;

    localparam logic [7:0] OFS_DATA = 8'h00;
    localparam logic [7:0] OFS_RSR  = 8'h01;
    localparam logic [7:0] OFS_FLAG = 8'h06;
    localparam logic [7:0] OFS_IBRD = 8'h09;
    localparam logic [7:0] OFS_FBRD = 8'h0A;
    localparam logic [7:0] OFS_LCR  = 8'h0B;
    localparam logic [7:0] OFS_CTL  = 8'h0C;
    localparam logic [7:0] OFS_LVL  = 8'h0D;
    localparam logic [7:0] OFS_MASK = 8'h0E;
    localparam logic [7:0] OFS_RIS  = 8'h0F;
    localparam logic [7:0] OFS_MIS  = 8'h10;
    localparam logic [7:0] OFS_ICR  = 8'h11;

    localparam logic [REG_W-1:0] MSK_FBRD = 16'h003F;
    localparam logic [REG_W-1:0] MSK_LCR  = 16'h00FF;
    localparam logic [REG_W-1:0] MSK_CTL  = 16'hFFC7;
    localparam logic [REG_W-1:0] MSK_LVL  = 16'h003F;
    localparam logic [REG_W-1:0] LVL_INIT = 16'h0012;

    localparam int BIT_RX = 4;
    localparam int BIT_TX = 5;
    localparam int BIT_RT = 6;
    localparam int BIT_BUF_ON = 4;
    localparam int BIT_LOOP = 7;

    localparam logic [63:0] IDENT = 64'hB105F00D_00241011;

    typedef enum logic [3:0] {
        SEL_DATA, SEL_RSR, SEL_FLAG, SEL_IBRD, SEL_FBRD, SEL_LCR, SEL_CTL,
        SEL_LVL, SEL_MASK, SEL_RIS, SEL_MIS, SEL_ICR, SEL_ID, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] ibrd;
        logic [REG_W-1:0] fbrd;
        logic [REG_W-1:0] lcr;
        logic [REG_W-1:0] ctl;
        logic [REG_W-1:0] lvl;
        logic [IRQ_W-1:0] mask;
    } csr_t;

    function automatic logic [7:0] ident_byte(input logic [2:0] idx);
        return IDENT[idx*8 +: 8];
    endfunction

    function automatic int unsigned rx_trigger(input logic buf_on,
                                               input logic [2:0] code,
                                               input int unsigned depth);
        if (!buf_on) return 1;
        case (code)
            3'd0:    return depth / 8;
            3'd1:    return depth / 4;
            3'd2:    return depth / 2;
            3'd3:    return depth * 3 / 4;
            3'd4:    return depth * 7 / 8;
            default: return depth;
        endcase
    endfunction

endpackage

// File: rtl/uart_csr_decode.sv
module uart_csr_decode
    import uart_csr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [2:0]        id_idx
);
    always_comb begin
        sel    = SEL_NONE;
        id_idx = addr[2:0];
        if (&addr[ADDR_W-1:3]) begin
            sel = SEL_ID;
        end else if ((addr >> 8) == '0) begin
            case (addr[7:0])
                OFS_DATA: sel = SEL_DATA;
                OFS_RSR:  sel = SEL_RSR;
                OFS_FLAG: sel = SEL_FLAG;
                OFS_IBRD: sel = SEL_IBRD;
                OFS_FBRD: sel = SEL_FBRD;
                OFS_LCR:  sel = SEL_LCR;
                OFS_CTL:  sel = SEL_CTL;
                OFS_LVL:  sel = SEL_LVL;
                OFS_MASK: sel = SEL_MASK;
                OFS_RIS:  sel = SEL_RIS;
                OFS_MIS:  sel = SEL_MIS;
                OFS_ICR:  sel = SEL_ICR;
                default:  sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/uart_csr_store.sv
module uart_csr_store
    import uart_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  reg_sel_e         sel,
    input  logic [REG_W-1:0] wdata,
    input  logic             overrun,
    output csr_t             csr,
    output logic             oe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            csr     <= '0;
            csr.lvl <= LVL_INIT;
        end else if (wr) begin
            case (sel)
                SEL_IBRD: csr.ibrd <= wdata;
                SEL_FBRD: csr.fbrd <= wdata & MSK_FBRD;
                SEL_LCR:  csr.lcr  <= wdata & MSK_LCR;
                SEL_CTL:  csr.ctl  <= wdata & MSK_CTL;
                SEL_LVL:  csr.lvl  <= wdata & MSK_LVL;
                SEL_MASK: csr.mask <= wdata[IRQ_W-1:0];
                default:  ;
            endcase
        end
    end

    // receive error state: overrun sets, any status write clears, set wins
    always_ff @(posedge clk) begin
        if (rst)                        oe <= 1'b0;
        else if (overrun)               oe <= 1'b1;
        else if (wr && sel == SEL_RSR)  oe <= 1'b0;
    end
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
    import uart_csr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             buf_on,
    input  logic [2:0]       trig_code,
    input  logic [IRQ_W-1:0] mask,
    input  logic [LVL_W-1:0] level,
    input  logic             arrive,
    input  logic             data_wr,
    input  logic             data_rd,
    input  logic             clr_wr,
    input  logic [IRQ_W-1:0] clr_bits,
    output logic [IRQ_W-1:0] raw,
    output logic             irq
);
    logic [LVL_W-1:0] trig;
    logic [LVL_W-1:0] level_prev;
    logic [LVL_W-1:0] level_after;
    logic [IRQ_W-1:0] set_v;
    logic [IRQ_W-1:0] clr_v;

    assign trig        = LVL_W'(rx_trigger(buf_on, trig_code, DEPTH));
    assign level_after = (level == '0) ? '0 : level - 1'b1;

    always_comb begin
        set_v = '0;
        clr_v = '0;
        if (level_prev < trig && level >= trig) set_v[BIT_RX] = 1'b1;
        if (arrive && level != '0)              set_v[BIT_RT] = 1'b1;
        if (data_wr)                            set_v[BIT_TX] = 1'b1;
        if (clr_wr)                             clr_v = clr_bits;
        if (data_rd) begin
            if (level_after < trig) clr_v[BIT_RX] = 1'b1;
            if (level_after == '0)  clr_v[BIT_RT] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw        <= '0;
            level_prev <= '0;
        end else begin
            raw        <= (raw & ~clr_v) | set_v;
            level_prev <= level;
        end
    end

    assign irq = |(raw & mask);
endmodule

// File: rtl/uart_csr_top.sv
module uart_csr_top
    import uart_csr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DEPTH  = 16,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [7:0]        rx_char,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              rx_arrive,
    input  logic              rx_overrun,
    output logic              rx_pop,
    output logic              tx_push,
    output logic              lb_push,
    output logic [7:0]        tx_byte,
    output logic              fifo_en,
    output logic              irq
);
    reg_sel_e         sel;
    logic [2:0]       id_idx;
    csr_t             csr_q;
    logic             oe_q;
    logic [IRQ_W-1:0] irq_raw;
    logic             data_wr;
    logic [LVL_W-1:0] eff_depth;
    logic             rx_full;
    logic [31:0]      rd_val;

    uart_csr_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr   (bus_addr),
        .sel    (sel),
        .id_idx (id_idx)
    );

    uart_csr_store i_store (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .sel     (sel),
        .wdata   (bus_wdata),
        .overrun (rx_overrun),
        .csr     (csr_q),
        .oe      (oe_q)
    );

    assign data_wr = bus_wr && sel == SEL_DATA;
    assign rx_pop  = bus_rd && sel == SEL_DATA;
    assign tx_push = data_wr && !csr_q.ctl[BIT_LOOP];
    assign lb_push = data_wr &&  csr_q.ctl[BIT_LOOP];
    assign tx_byte = bus_wdata[7:0];
    assign fifo_en = csr_q.lcr[BIT_BUF_ON];

    uart_irq_unit #(.DEPTH(DEPTH), .LVL_W(LVL_W)) i_irq (
        .clk       (clk),
        .rst       (rst),
        .buf_on    (fifo_en),
        .trig_code (csr_q.lvl[5:3]),
        .mask      (csr_q.mask),
        .level     (rx_level),
        .arrive    (rx_arrive),
        .data_wr   (data_wr),
        .data_rd   (rx_pop),
        .clr_wr    (bus_wr && sel == SEL_ICR),
        .clr_bits  (bus_wdata[IRQ_W-1:0]),
        .raw       (irq_raw),
        .irq       (irq)
    );

    assign eff_depth = fifo_en ? LVL_W'(DEPTH) : LVL_W'(1);
    assign rx_full   = rx_level >= eff_depth;

    always_comb begin
        rd_val = '0;
        case (sel)
            SEL_DATA: rd_val = {16'h0, 4'h0, oe_q, 3'b000, rx_char};
            SEL_RSR:  rd_val = {28'h0, oe_q, 3'b000};
            SEL_FLAG: rd_val = {24'h0, 1'b1, rx_full, 1'b0, rx_level == '0, 4'h0};
            SEL_IBRD: rd_val = {16'h0, csr_q.ibrd};
            SEL_FBRD: rd_val = {16'h0, csr_q.fbrd};
            SEL_LCR:  rd_val = {16'h0, csr_q.lcr};
            SEL_CTL:  rd_val = {16'h0, csr_q.ctl};
            SEL_LVL:  rd_val = {16'h0, csr_q.lvl};
            SEL_MASK: rd_val = {21'h0, csr_q.mask};
            SEL_RIS:  rd_val = {21'h0, irq_raw};
            SEL_MIS:  rd_val = {21'h0, irq_raw & csr_q.mask};
            SEL_ID:   rd_val = {24'h0, ident_byte(id_idx)};
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end
endmodule

// File: rtl/uart_csr_chk.sv
module uart_csr_chk
    import uart_csr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic              rx_overrun,
    input logic              tx_push,
    input logic              lb_push,
    input logic              irq,
    input logic [IRQ_W-1:0]  raw,
    input logic [IRQ_W-1:0]  mask,
    input logic              oe
);
    // R7
    tx_set_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_DATA)) |=> raw[BIT_TX]);

    // R4
    w1c_drops_tx_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_ICR) && bus_wdata[BIT_TX]) |=> !raw[BIT_TX]);

    // R5
    status_write_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_RSR) && !rx_overrun) |=> !oe);

    // R5
    overrun_sets_chk: assert property (@(posedge clk) disable iff (rst)
        rx_overrun |=> oe);

    // R3
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq);

    // R7
    one_route_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_push, lb_push}));
endmodule

bind uart_csr_top uart_csr_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .rx_overrun (rx_overrun),
    .tx_push    (tx_push),
    .lb_push    (lb_push),
    .irq        (irq),
    .raw        (irq_raw),
    .mask       (csr_q.mask),
    .oe         (oe_q)
);

// File: tb/test_uart_csr_top.sv
module test_uart_csr_top;
    localparam int ADDR_W = 10;
    localparam int DEPTH  = 16;
    localparam int LVL_W  = 5;

    logic              clk = 1'b0;
    logic              rst;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [7:0]        rx_char = '0;
    logic [LVL_W-1:0]  rx_level = '0;
    logic              rx_arrive = 1'b0, rx_overrun = 1'b0;
    logic              rx_pop, tx_push, lb_push, fifo_en, irq;
    logic [7:0]        tx_byte;

    int n_chk = 0;
    int n_err = 0;

    // reference state
    logic [15:0] m_ibrd, m_fbrd, m_lcr, m_ctl, m_lvl;
    logic [10:0] m_mask, m_raw;
    logic        m_oe;
    int          m_prev;

    always #5 clk = ~clk;

    uart_csr_top #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) i_uart_csr_top (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_char(rx_char),
        .rx_level(rx_level), .rx_arrive(rx_arrive), .rx_overrun(rx_overrun),
        .rx_pop(rx_pop), .tx_push(tx_push), .lb_push(lb_push), .tx_byte(tx_byte),
        .fifo_en(fifo_en), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int trig_of();
        if (!m_lcr[4]) return 1;
        case (m_lvl[5:3])
            3'd0: return DEPTH / 8;
            3'd1: return DEPTH / 4;
            3'd2: return DEPTH / 2;
            3'd3: return DEPTH * 3 / 4;
            3'd4: return DEPTH * 7 / 8;
            default: return DEPTH;
        endcase
    endfunction

    function automatic logic [7:0] ident(input int idx);
        logic [63:0] w = 64'hB105F00D_00241011;
        return w[idx*8 +: 8];
    endfunction

    function automatic string req_of(input int a);
        case (a)
            'h00: return "R6";
            'h01: return "R5";
            'h06: return "R8";
            'h09, 'h0A, 'h0B, 'h0C, 'h0D, 'h0E: return "R2";
            'h0F, 'h10: return "R3";
            'h11: return "R4";
            default: return (a >= 'h3F8) ? "R9" : "R10";
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input int a, input int lvl, input logic [7:0] ch);
        int eff = m_lcr[4] ? DEPTH : 1;
        case (a)
            'h00: return {16'h0, 4'h0, m_oe, 3'b0, ch};
            'h01: return {28'h0, m_oe, 3'b0};
            'h06: return {24'h0, 1'b1, lvl >= eff, 1'b0, lvl == 0, 4'h0};
            'h09: return {16'h0, m_ibrd};
            'h0A: return {16'h0, m_fbrd};
            'h0B: return {16'h0, m_lcr};
            'h0C: return {16'h0, m_ctl};
            'h0D: return {16'h0, m_lvl};
            'h0E: return {21'h0, m_mask};
            'h0F: return {21'h0, m_raw};
            'h10: return {21'h0, m_raw & m_mask};
            default: return (a >= 'h3F8) ? {24'h0, ident(a - 'h3F8)} : 32'h0;
        endcase
    endfunction

    task automatic step(input logic wr, input logic rd, input int a, input logic [15:0] wd,
                        input int lvl, input logic arr, input logic ovr, input logic [7:0] ch);
        logic [31:0] er;
        logic [10:0] setv, clrv;
        int trig, aft;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = ADDR_W'(a); bus_wdata = wd;
        rx_level = LVL_W'(lvl); rx_arrive = arr; rx_overrun = ovr; rx_char = ch;
        #1;
        // R7 routing and R6 pop, same cycle
        check("R7 send", {31'h0, tx_push}, {31'h0, wr && a == 0 && !m_ctl[7]});
        check("R7 loop", {31'h0, lb_push}, {31'h0, wr && a == 0 && m_ctl[7]});
        if (wr && a == 0) check("R7 byte", {24'h0, tx_byte}, {24'h0, wd[7:0]});
        check("R6 pop", {31'h0, rx_pop}, {31'h0, rd && a == 0});
        er = exp_read(a, lvl, ch);
        trig = trig_of();
        setv = '0; clrv = '0;
        if (m_prev < trig && lvl >= trig) setv[4] = 1'b1;
        if (arr && lvl != 0) setv[6] = 1'b1;
        if (wr && a == 0) setv[5] = 1'b1;
        if (wr && a == 'h11) clrv = wd[10:0];
        if (rd && a == 0) begin
            aft = (lvl == 0) ? 0 : lvl - 1;
            if (aft < trig) clrv[4] = 1'b1;
            if (aft == 0) clrv[6] = 1'b1;
        end
        @(posedge clk);
        m_raw = (m_raw & ~clrv) | setv;
        if (ovr) m_oe = 1'b1;
        else if (wr && a == 1) m_oe = 1'b0;
        if (wr) begin
            case (a)
                'h09: m_ibrd = wd;
                'h0A: m_fbrd = wd & 16'h003F;
                'h0B: m_lcr = wd & 16'h00FF;
                'h0C: m_ctl = wd & 16'hFFC7;
                'h0D: m_lvl = wd & 16'h003F;
                'h0E: m_mask = wd[10:0];
                default: ;
            endcase
        end
        m_prev = lvl;
        #2;
        // R13 read data due one edge after the strobe
        if (rd) check(req_of(a), bus_rdata, er);
        // R3 R11 R12 raw state seen through the interrupt line
        check("R3 irq", {31'h0, irq}, {31'h0, |(m_raw & m_mask)});
        check("R8 buffer enable", {31'h0, fifo_en}, {31'h0, m_lcr[4]});
        bus_wr = 1'b0; bus_rd = 1'b0; rx_arrive = 1'b0; rx_overrun = 1'b0;
    endtask

    task automatic rd_reg(input int a, input int lvl);
        step(1'b0, 1'b1, a, 16'h0, lvl, 1'b0, 1'b0, 8'h5A);
    endtask

    task automatic wr_reg(input int a, input logic [15:0] d, input int lvl);
        step(1'b1, 1'b0, a, d, lvl, 1'b0, 1'b0, 8'h00);
    endtask

    initial begin
        #(200000 * 10);
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    int addrs[16] = '{'h00, 'h01, 'h06, 'h09, 'h0A, 'h0B, 'h0C, 'h0D,
                      'h0E, 'h0F, 'h10, 'h11, 'h02, 'h3F8, 'h3FD, 'h1F};

    initial begin
        int lvl;
        void'($urandom(32'd20240611));
        m_ibrd = 0; m_fbrd = 0; m_lcr = 0; m_ctl = 0; m_lvl = 16'h0012;
        m_mask = 0; m_raw = 0; m_oe = 0; m_prev = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #2;
        // R1 reset state
        check("R1 irq reset", {31'h0, irq}, 32'h0);
        check("R1 rdata reset", bus_rdata, 32'h0);
        foreach (addrs[i]) rd_reg(addrs[i], 0);

        // R2 masks
        for (int i = 'h09; i <= 'h0E; i++) begin
            wr_reg(i, 16'hFFFF, 0);
            rd_reg(i, 0);
        end
        // R10 read-only and unassigned writes ignored
        wr_reg('h0F, 16'hFFFF, 0); wr_reg('h10, 16'hFFFF, 0);
        wr_reg('h06, 16'hFFFF, 0); wr_reg('h05, 16'hFFFF, 0); wr_reg('h3FA, 16'hFFFF, 0);
        rd_reg('h0F, 0); rd_reg('h06, 0); rd_reg('h05, 0); rd_reg('h3FA, 0);
        wr_reg('h11, 16'h07FF, 0);

        // R9 identification bytes
        for (int i = 'h3F8; i <= 'h3FF; i++) rd_reg(i, 0);

        // R11 crossing with buffer enabled, selector 2 -> trigger DEPTH/2
        wr_reg('h0C, 16'h0000, 0);
        wr_reg('h0B, 16'h0010, 0);
        wr_reg('h0D, 16'h0010, 0);
        wr_reg('h0E, 16'h0050, 0);
        step(1'b0, 1'b0, 0, 0, 7, 1'b1, 1'b0, 8'h00);
        step(1'b0, 1'b0, 0, 0, 8, 1'b1, 1'b0, 8'h00);
        rd_reg('h0F, 8);
        // R12 pop below trigger clears receive, not timeout
        rd_reg('h00, 8);
        rd_reg('h0F, 7);
        // R12 last pop clears timeout
        rd_reg('h00, 1);
        rd_reg('h10, 0);
        // R5 overrun folded into data read and kept; write clears
        step(1'b0, 1'b0, 0, 0, 0, 1'b0, 1'b1, 8'h00);
        rd_reg('h00, 0); rd_reg('h01, 0);
        step(1'b1, 1'b0, 'h01, 16'h0, 0, 1'b0, 1'b1, 8'h00);
        rd_reg('h01, 0);
        wr_reg('h01, 16'h1234, 0);
        rd_reg('h01, 0);
        // R7 loopback route, transmit bit, R4 clear
        wr_reg('h0E, 16'h0020, 0);
        wr_reg('h00, 16'h00A5, 0);
        wr_reg('h0C, 16'h0080, 0);
        wr_reg('h00, 16'h003C, 0);
        wr_reg('h11, 16'h0020, 0);
        rd_reg('h11, 0);
        // R8 flags full and empty under both depths
        rd_reg('h06, 16); rd_reg('h06, 0);
        wr_reg('h0B, 16'h0000, 0);
        rd_reg('h06, 1);
        // R11 trigger 1 with buffer off
        step(1'b0, 1'b0, 0, 0, 0, 1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b0, 0, 0, 1, 1'b1, 1'b0, 8'h00);
        rd_reg('h0F, 1);

        // random mix
        lvl = 0;
        for (int n = 0; n < 3000; n++) begin
            int a, nl;
            logic w, r;
            a = addrs[$urandom_range(15)];
            if ($urandom_range(7) == 0) a = 'h3F8 + $urandom_range(7);
            r = $urandom_range(1);
            w = !r || ($urandom_range(7) == 0);
            nl = ($urandom_range(3) == 0) ? $urandom_range(DEPTH) : lvl;
            step(w, r, a, 16'($urandom()), nl, nl > lvl, $urandom_range(15) == 0,
                 8'($urandom()));
            lvl = nl;
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule